// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches one interrupt pin that toggles freely and without any relation to the core clock. It raises a single interrupt request toward a processor. The pin first passes through a synchronizer. A detector then compares each synchronized sample with the one before it, and a programmable sense mode decides which pin activity counts as an event: a low level, any change, a falling edge or a rising edge. Edge events set a sticky pending flag. Software clears that flag by writing a one to it. An enable mask gates the flag onto the request line.

Detection never stops. A pending flag therefore collects edges while the mask is off, and the request rises as soon as software enables the mask. The block also reproduces the side effect of reprogramming the sense mode. Changing the mode can make the detector see a pseudo-edge, which sets the flag even though the pin did not move. Software that wants to avoid this disables the mask, changes the mode, clears the flag and only then enables the mask.

The register port is a plain single-cycle bus with no handshake and no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. Reads are combinational from `bus_addr`.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, the sense register reads 0, the pending flag reads 0, the mask reads 0 and `irq` is low. Both synchronizer stages and the stored previous sample start high.
- R2: Register map. Address 0 holds the sense mode in bits [1:0]: 0 is low level, 1 is any change, 2 is falling edge, 3 is rising edge. Address 1 holds the pending flag in bit 0. Address 2 holds the mask in bit 0. Address 3 reads as 0. Unused read bits are 0.
- R3: A pin level first sampled at clock edge k reaches the detector at edge k+1. A qualifying edge sets the pending flag at edge k+2, where a read of address 1 shows it.
- R4: The detector sets the pending flag in the edge modes whether or not the mask is set.
- R5: `irq` is registered. At each edge it takes mask AND (flag OR (mode is low level AND synchronized pin is low)) from the cycle before. Writing mask=1 while the flag is set raises `irq` one edge after the write.
- R6: Writing address 1 with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: If the detector sets the flag in the same cycle as a clearing write, the flag ends set.
- R8: A sense write to a value different from the current one sets the flag in three cases: the new mode is any change; the new mode is falling and the synchronized pin is low; the new mode is rising and the synchronized pin is high. In the write cycle a real edge is also qualified against the new mode.
- R9: In low-level mode the flag is never set. The request follows the synchronized pin low, gated by the mask, with no memory.
- R10: A sense write that repeats the current mode, while the pin is steady, does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_async | input | 1 | Asynchronous external interrupt pin |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (2) | Register address for read and write |
| bus_wdata | input | REG_W (2) | Write data |
| bus_rdata | output | REG_W (2) | Combinational read data for `bus_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
A stuck or stale synchronizer stage shows up as a flag that rises one edge early or late compared with the R3 timing, so it is visible at the flag read within three edges of the pin change. A wrong pending flag or mask shows up at `irq` one edge later, and a wrong flag also shows at the address 1 read in the same cycle. A wrong mode-change rule appears as a flag set, or missing, at the edge right after the sense write. Because of this, the bench compares every cycle against a model built from the requirements and sweeps random writes and pin toggles.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_ANY  = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_RISE = 2'd3
  } sense_t;

  localparam int ADDR_SENSE = 0;
  localparam int ADDR_FLAG  = 1;
  localparam int ADDR_MASK  = 2;

  // Does the pair (previous, current) qualify under mode m?
  function automatic logic edge_hit(sense_t m, logic p, logic c);
    case (m)
      SENSE_ANY:  edge_hit = p ^ c;
      SENSE_FALL: edge_hit = p & ~c;
      SENSE_RISE: edge_hit = ~p & c;
      default:    edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eirq_event.sv
module eirq_event
  import eirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cur,
  input  sense_t mode,
  input  logic   sense_wr,
  input  sense_t sense_new,
  output logic   set_evt,
  output logic   level_low
);
  logic prev;
  logic pseudo;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= cur;
  end

  // A mode change makes the detector treat the pin as having just arrived
  // at its present level from the opposite one.
  always_comb begin
    pseudo = 1'b0;
    if (sense_wr && sense_new != mode)
      pseudo = edge_hit(sense_new, ~cur, cur);
  end

  assign set_evt   = edge_hit(mode, prev, cur)
                   | (sense_wr & (edge_hit(sense_new, prev, cur) | pseudo));
  assign level_low = (mode == SENSE_LOW) & ~cur;

  // R9
  level_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW && !sense_wr) |-> !set_evt);
  // R10
  same_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_wr && sense_new == mode && prev == cur) |-> !set_evt);
endmodule

// File: rtl/eirq_flag_core.sv
module eirq_flag_core (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  input  logic mask_wr,
  input  logic mask_val,
  input  logic level_low,
  output logic flag,
  output logic mask,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      mask <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (set_evt)     flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
      if (mask_wr)     mask <= mask_val;
      irq <= mask & (flag | level_low);
    end
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_evt) |=> !flag);
  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask |=> !irq);
  // R5
  pending_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && flag) |=> irq);
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2,
  parameter int REG_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_async,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(ADDR_SENSE);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(ADDR_FLAG);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(ADDR_MASK);

  logic   pin_s, set_evt, level_low, flag, mask;
  logic   sense_wr, clr_wr, mask_wr;
  sense_t mode, sense_new;

  assign sense_wr  = bus_wr && bus_addr == A_SENSE;
  assign clr_wr    = bus_wr && bus_addr == A_FLAG && bus_wdata[0];
  assign mask_wr   = bus_wr && bus_addr == A_MASK;
  assign sense_new = sense_t'(bus_wdata[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)        mode <= SENSE_LOW;
    else if (sense_wr) mode <= sense_new;
  end

  eirq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin_async), .q(pin_s)
  );

  eirq_event event_i (
    .clk(clk), .rst_n(rst_n), .cur(pin_s), .mode(mode),
    .sense_wr(sense_wr), .sense_new(sense_new),
    .set_evt(set_evt), .level_low(level_low)
  );

  eirq_flag_core core_i (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_wr(clr_wr),
    .mask_wr(mask_wr), .mask_val(bus_wdata[0]), .level_low(level_low),
    .flag(flag), .mask(mask), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_SENSE)     bus_rdata = REG_W'(mode);
    else if (bus_addr == A_FLAG) bus_rdata = REG_W'(flag);
    else if (bus_addr == A_MASK) bus_rdata = REG_W'(mask);
  end

  // R8
  spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_wr && sense_new == SENSE_ANY && mode != SENSE_ANY) |=> flag);
  // R4
  edge_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_ANY && !sense_wr && $changed(pin_s)) |=> flag);
endmodule

// File: tb/eirq_ctrl_tb.sv
module eirq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [1:0] wdata = 2'd0;
  logic [1:0] rdata;
  logic       irq;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  eirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_async(pin), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  // Reference state built from the requirements
  logic       m_s1, m_s2, m_prev, m_flag, m_mask, m_irq;
  logic [1:0] m_mode;

  function automatic logic hit(logic [1:0] m, logic p, logic c);
    case (m)
      2'd1:    return p ^ c;
      2'd2:    return p & ~c;
      2'd3:    return ~p & c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return m_mode;
      2'd1:    return {1'b0, m_flag};
      2'd2:    return {1'b0, m_mask};
      default: return 2'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_s1 = 1; m_s2 = 1; m_prev = 1; m_flag = 0; m_mask = 0; m_irq = 0; m_mode = 0;
  endtask

  task automatic model_step();
    logic cur, set, swr, clr, spur, irq_n;
    cur = m_s2;
    swr = wr && addr == 2'd0;
    clr = wr && addr == 2'd1 && wdata[0];
    spur = swr && wdata != m_mode && hit(wdata, ~cur, cur);
    set = hit(m_mode, m_prev, cur) | (swr & (hit(wdata, m_prev, cur) | spur));
    irq_n = m_mask & (m_flag | (m_mode == 2'd0 & ~cur));
    if (set) m_flag = 1; else if (clr) m_flag = 0;
    if (wr && addr == 2'd2) m_mask = wdata[0];
    if (swr) m_mode = wdata;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    m_irq = irq_n;
  endtask

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(string tag, logic p, logic w, logic [1:0] a, logic [1:0] d);
    pin = p; wr = w; addr = a; wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " irq"}, {1'b0, irq}, {1'b0, m_irq});
    check({tag, " rdata"}, rdata, exp_read(addr));
  endtask

  task automatic rd(string tag, logic [1:0] a, logic [1:0] exp);
    wr = 0; addr = a;
    #0.5;
    check(tag, rdata, exp);
    check({tag, " model"}, rdata, exp_read(a));
  endtask

  initial begin
    #(4 * 150000);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    check("R1 irq after reset", {1'b0, irq}, 2'd0);
    rd("R1 sense reset", 2'd0, 2'd0);
    rd("R1 flag reset", 2'd1, 2'd0);
    rd("R1 mask reset", 2'd2, 2'd0);
    rd("R2 unused addr", 2'd3, 2'd0);

    // R8: switch to rising with pin high -> pseudo edge sets flag
    step("R8 to rise", 1, 1, 2'd0, 2'd3);
    step("R8 look", 1, 0, 2'd1, 2'd0);
    rd("R8 flag after mode change", 2'd1, 2'd1);
    // R6: write 0 no effect, write 1 clears
    step("R6 w0", 1, 1, 2'd1, 2'd0);
    rd("R6 write zero keeps", 2'd1, 2'd1);
    step("R6 w1", 1, 1, 2'd1, 2'd1);
    rd("R6 write one clears", 2'd1, 2'd0);
    // R10: same mode rewrite
    step("R10 same", 1, 1, 2'd0, 2'd3);
    step("R10 look", 1, 0, 2'd1, 2'd0);
    rd("R10 no set on same mode", 2'd1, 2'd0);
    // R3/R4: rising edge with mask off, timing
    for (int i = 0; i < 4; i++) step("R3 low", 0, 0, 2'd1, 2'd0);
    step("R3 rise A", 1, 0, 2'd1, 2'd0);
    rd("R3 not yet A", 2'd1, 2'd0);
    step("R3 rise B", 1, 0, 2'd1, 2'd0);
    rd("R3 not yet B", 2'd1, 2'd0);
    step("R3 rise C", 1, 0, 2'd1, 2'd0);
    rd("R4 flag set while masked", 2'd1, 2'd1);
    check("R4 irq stays low", {1'b0, irq}, 2'd0);
    // R5: enable with pending flag
    step("R5 enable", 1, 1, 2'd2, 2'd1);
    check("R5 not same edge", {1'b0, irq}, 2'd0);
    step("R5 next", 1, 0, 2'd1, 2'd0);
    check("R5 irq at once", {1'b0, irq}, 2'd1);
    // R7: clear in the cycle of a real falling edge under any-change mode
    step("R7 mode any", 1, 1, 2'd0, 2'd1);
    step("R7 clr", 1, 1, 2'd1, 2'd1);
    for (int i = 0; i < 3; i++) step("R7 settle", 1, 0, 2'd1, 2'd0);
    step("R7 fall", 0, 0, 2'd1, 2'd0);
    step("R7 fall2", 0, 0, 2'd1, 2'd0);
    step("R7 clash", 0, 1, 2'd1, 2'd1);
    rd("R7 set beats clear", 2'd1, 2'd1);
    // R9: low level mode, no flag, irq follows pin
    step("R9 to low", 0, 1, 2'd0, 2'd0);
    step("R9 clr", 0, 1, 2'd1, 2'd1);
    for (int i = 0; i < 3; i++) step("R9 low pin", 0, 0, 2'd1, 2'd0);
    check("R9 irq on low level", {1'b0, irq}, 2'd1);
    rd("R9 no flag in level mode", 2'd1, 2'd0);
    for (int i = 0; i < 4; i++) step("R9 high pin", 1, 0, 2'd1, 2'd0);
    check("R9 irq drops", {1'b0, irq}, 2'd0);

    // R2: random sweep
    for (int i = 0; i < 4000; i++) begin
      logic p, w;
      p = ($urandom % 5 == 0) ? ~pin : pin;
      w = ($urandom % 3 == 0);
      step("R2 random", p, w, 2'($urandom), 2'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule